// File: doc/BRIEF.md
# Boot Window Command Decoder

This block watches bus writes that land in the two word windows of a flash device's boot buffer (word offsets 0x0000 to 0x01FF and 0x8000 to 0x800F). It reads the data word of each such write as a boot command. Three commands are understood: a soft reset, a two-write page-load sequence and a read-identification command. All other values are dropped.

The block owns the page address register used by the page-load sequence. Each issued load moves that register forward by one page step. The surrounding device supplies the current block address, the identification words, the write-protection status and a busy flag from the page-load engine. In return, the block raises a one-cycle reset request, a one-cycle page-load request with the block and page to fetch, and a short burst of writes that places identification bytes in the first three buffer entries.

Top module: `boot_cmd_decoder`

## Requirements
- R1: Only writes with wrAddr below 0x0200, or from 0x8000 to 0x800F inclusive, are treated as commands. A write outside both windows has no effect on any output and does not consume an armed load sequence.
- R2: A command value of 0x00F0 raises resetReq for exactly the one cycle after the write. It also clears the page register to 0 and cancels a load request that is still waiting for the busy flag.
- R3: A command value of 0x00E0 arms the load sequence. The next window write is consumed as its second step whatever its value: a non-zero value in that step requests nothing and is not decoded as a command (for example 0x00F0 gives no reset).
- R4: A second-step value of 0x0000 makes loadReq a one-cycle pulse two cycles after that write, when the load engine is idle. loadBlock then carries blockAddr and loadPage carries the page register.
- R5: Each issued load advances the page register by 4, modulo 256 (0xFC is followed by 0x00).
- R6: While loadBusy is high, a requested load waits, and no loadReq is raised. It is issued as a single pulse on the cycle after loadBusy falls.
- R7: A command value of 0x0090 produces idWrEn on three consecutive cycles, starting the cycle after the write. The indices are 0, 1, 2 and the data is {8'h00, mfrId[7:0]}, {8'h00, devId[7:0]}, {8'h00, wpStatus[7:0]} in that order, so the upper byte of each entry is cleared.
- R8: Any other value written outside the second step of a load sequence (including 0x0000 when not armed) produces no output activity.
- R9: A write with pageWrEn high loads pageWrData into the page register. This value is used by the next issued load.
- R10: After reset all request outputs are low and the page register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 16 | Bus write word offset |
| wrData | input | 16 | Bus write data |
| blockAddr | input | 16 | Current block address for page loads |
| pageWrEn | input | 1 | Load the page register |
| pageWrData | input | 8 | New page register value |
| loadBusy | input | 1 | Page-load engine busy |
| mfrId | input | 16 | Manufacturer identification word |
| devId | input | 16 | Device identification word |
| wpStatus | input | 16 | Write-protection status word |
| resetReq | output | 1 | One-cycle soft reset request |
| loadReq | output | 1 | One-cycle page-load request |
| loadBlock | output | 16 | Block address of the load request |
| loadPage | output | 8 | Page address of the load request |
| idWrEn | output | 1 | Boot buffer identification write strobe |
| idWrIdx | output | 2 | Buffer entry index of the identification write |
| idWrData | output | 16 | Data of the identification write |

## Verification
The embedded properties check several rules on every cycle. A load request lasts one cycle and never follows a busy cycle. The page register sits exactly one step past the issued page. A reset cycle carries no load or identification activity. An identification index never reaches 3. Only the bench scenarios can show which windows decode, which value the armed step consumes, the exact bytes placed by a read-identification, the 8-bit wrap of the page register and the cancelling of a waiting load by a reset.

// File: rtl/boot_cmd_pkg.sv
`timescale 1ns/1ps
package boot_cmd_pkg;
  localparam logic [15:0] CMD_SOFT_RESET = 16'h00F0;
  localparam logic [15:0] CMD_ARM_LOAD   = 16'h00E0;
  localparam logic [15:0] CMD_READ_ID    = 16'h0090;
  localparam logic [15:0] CONFIRM_LOAD   = 16'h0000;

  typedef struct packed {
    logic doReset;
    logic doConfirm;
    logic doReadId;
  } ctrlStrobes_t;
endpackage

// File: rtl/boot_cmd_ctrl.sv
`timescale 1ns/1ps
module boot_cmd_ctrl
  import boot_cmd_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int LOW_WIN_WORDS  = 'h200,
  parameter int HIGH_WIN_BASE  = 'h8000,
  parameter int HIGH_WIN_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] LowEnd  = ADDR_W'(LOW_WIN_WORDS);
  localparam logic [ADDR_W-1:0] HighLo  = ADDR_W'(HIGH_WIN_BASE);
  localparam logic [ADDR_W-1:0] HighEnd = ADDR_W'(HIGH_WIN_BASE + HIGH_WIN_WORDS);

  logic hitLow, hitHigh, cmdWrite, armed;

  assign hitLow   = wrAddr < LowEnd;
  assign hitHigh  = (wrAddr >= HighLo) && (wrAddr < HighEnd);
  assign cmdWrite = wrEn && (hitLow || hitHigh);

  always_comb begin
    strobes = '0;
    if (cmdWrite) begin
      if (armed) begin
        strobes.doConfirm = (wrData == DATA_W'(CONFIRM_LOAD));
      end else begin
        case (wrData)
          DATA_W'(CMD_SOFT_RESET): strobes.doReset  = 1'b1;
          DATA_W'(CMD_READ_ID):    strobes.doReadId = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (cmdWrite) begin
      armed <= !armed && (wrData == DATA_W'(CMD_ARM_LOAD));
    end
  end

  // R3: the armed step never decodes a command
  p_armed_consumes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && armed) |-> (!strobes.doReset && !strobes.doReadId));

  // R1: writes outside the windows raise no strobe
  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hitLow && !hitHigh) |-> (strobes == '0));
endmodule

// File: rtl/boot_cmd_dp.sv
`timescale 1ns/1ps
module boot_cmd_dp
  import boot_cmd_pkg::*;
#(
  parameter int BLOCK_W   = 16,
  parameter int PAGE_W    = 8,
  parameter int PAGE_STEP = 4,
  parameter int ID_W      = 16,
  parameter int ID_BYTES  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [BLOCK_W-1:0] blockAddr,
  input  logic               pageWrEn,
  input  logic [PAGE_W-1:0]  pageWrData,
  input  logic               loadBusy,
  input  logic [ID_W-1:0]    mfrId,
  input  logic [ID_W-1:0]    devId,
  input  logic [ID_W-1:0]    wpStatus,
  output logic               resetReq,
  output logic               loadReq,
  output logic [BLOCK_W-1:0] loadBlock,
  output logic [PAGE_W-1:0]  loadPage,
  output logic               idWrEn,
  output logic [1:0]         idWrIdx,
  output logic [ID_W-1:0]    idWrData
);
  localparam logic [PAGE_W-1:0] StepVal = PAGE_W'(PAGE_STEP);
  localparam logic [1:0]        LastIdx = 2'(ID_BYTES - 1);

  logic [PAGE_W-1:0] pageReg;
  logic              reqPend;
  logic              idRun;
  logic [1:0]        idCnt;
  logic [7:0]        idByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq  <= 1'b0;
      loadReq   <= 1'b0;
      loadBlock <= '0;
      loadPage  <= '0;
      pageReg   <= '0;
      reqPend   <= 1'b0;
      idRun     <= 1'b0;
      idCnt     <= '0;
    end else begin
      resetReq <= strobes.doReset;
      loadReq  <= 1'b0;
      if (strobes.doReset) begin
        pageReg <= '0;
        reqPend <= 1'b0;
        idRun   <= 1'b0;
        idCnt   <= '0;
      end else begin
        if (reqPend && !loadBusy) begin
          loadReq   <= 1'b1;
          loadBlock <= blockAddr;
          loadPage  <= pageReg;
          pageReg   <= pageReg + StepVal;
          reqPend   <= 1'b0;
        end
        if (strobes.doConfirm) reqPend <= 1'b1;
        if (pageWrEn) pageReg <= pageWrData;
        if (strobes.doReadId) begin
          idRun <= 1'b1;
          idCnt <= '0;
        end else if (idRun) begin
          idCnt <= idCnt + 2'd1;
          if (idCnt == LastIdx) idRun <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (idCnt)
      2'd0:    idByte = mfrId[7:0];
      2'd1:    idByte = devId[7:0];
      default: idByte = wpStatus[7:0];
    endcase
  end

  assign idWrEn   = idRun;
  assign idWrIdx  = idCnt;
  assign idWrData = ID_W'(idByte);

  // R4: a load request lasts a single cycle
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> !loadReq);

  // R6: no request follows a busy cycle
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |-> !$past(loadBusy));

  // R5: the page register sits one step past the issued page
  p_page_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !$past(pageWrEn)) |-> (pageReg == PAGE_W'(loadPage + StepVal)));

  // R2: a reset cycle carries no other activity
  p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (!loadReq && !idWrEn));

  // R7: identification index stays within the three entries
  p_id_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    idWrEn |-> (idWrIdx <= LastIdx));
endmodule

// File: rtl/boot_cmd_decoder.sv
`timescale 1ns/1ps
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BLOCK_W   = 16,
  parameter int PAGE_W    = 8,
  parameter int PAGE_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [BLOCK_W-1:0] blockAddr,
  input  logic               pageWrEn,
  input  logic [PAGE_W-1:0]  pageWrData,
  input  logic               loadBusy,
  input  logic [DATA_W-1:0]  mfrId,
  input  logic [DATA_W-1:0]  devId,
  input  logic [DATA_W-1:0]  wpStatus,
  output logic               resetReq,
  output logic               loadReq,
  output logic [BLOCK_W-1:0] loadBlock,
  output logic [PAGE_W-1:0]  loadPage,
  output logic               idWrEn,
  output logic [1:0]         idWrIdx,
  output logic [DATA_W-1:0]  idWrData
);
  ctrlStrobes_t strobes;

  boot_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobes(strobes)
  );

  boot_cmd_dp #(.BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .PAGE_STEP(PAGE_STEP),
                .ID_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .blockAddr(blockAddr),
    .pageWrEn(pageWrEn), .pageWrData(pageWrData), .loadBusy(loadBusy),
    .mfrId(mfrId), .devId(devId), .wpStatus(wpStatus),
    .resetReq(resetReq), .loadReq(loadReq), .loadBlock(loadBlock),
    .loadPage(loadPage), .idWrEn(idWrEn), .idWrIdx(idWrIdx),
    .idWrData(idWrData)
  );
endmodule

// File: tb/sim_boot_cmd_decoder.sv
`timescale 1ns/1ps
module sim_boot_cmd_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, wrEn = 1'b0, pageWrEn = 1'b0, loadBusy = 1'b0;
  logic [15:0] wrAddr = '0, wrData = '0, blockAddr = 16'h0123;
  logic [7:0]  pageWrData = '0;
  logic [15:0] mfrId = 16'hBBEC, devId = 16'hCC25, wpStatus = 16'hDD02;
  logic resetReq, loadReq, idWrEn;
  logic [15:0] loadBlock, idWrData;
  logic [7:0]  loadPage;
  logic [1:0]  idWrIdx;

  boot_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .blockAddr(blockAddr), .pageWrEn(pageWrEn), .pageWrData(pageWrData),
    .loadBusy(loadBusy), .mfrId(mfrId), .devId(devId), .wpStatus(wpStatus),
    .resetReq(resetReq), .loadReq(loadReq), .loadBlock(loadBlock),
    .loadPage(loadPage), .idWrEn(idWrEn), .idWrIdx(idWrIdx),
    .idWrData(idWrData)
  );

  int checks = 0, errors = 0;
  int nRst, nLoad, nId;
  logic [7:0]  gotPage;
  logic [15:0] gotBlock;
  logic [15:0] gotId [3];

  // {addr, data, expReset, expLoad, expIdWrites}
  localparam int NV = 14;
  localparam logic [35:0] VECS [NV] = '{
    {16'h0000, 16'h0090, 1'b0, 1'b0, 2'd3},  // R7 read id, R1 low window
    {16'h800F, 16'h00F0, 1'b1, 1'b0, 2'd0},  // R2 reset, R1 high window top
    {16'h0200, 16'h00F0, 1'b0, 1'b0, 2'd0},  // R1 just above low window
    {16'h7FFF, 16'h0090, 1'b0, 1'b0, 2'd0},  // R1 below high window
    {16'h8010, 16'h00F0, 1'b0, 1'b0, 2'd0},  // R1 just above high window
    {16'h01FF, 16'h00E0, 1'b0, 1'b0, 2'd0},  // R3 arm at low window top
    {16'h0300, 16'h0000, 1'b0, 1'b0, 2'd0},  // R1 outside does not consume
    {16'h8000, 16'h0000, 1'b0, 1'b1, 2'd0},  // R4 confirm, page 0
    {16'h0010, 16'h00E0, 1'b0, 1'b0, 2'd0},  // R3 arm
    {16'h0010, 16'h00F0, 1'b0, 1'b0, 2'd0},  // R3 consumed, no reset
    {16'h0010, 16'h0000, 1'b0, 1'b0, 2'd0},  // R8 zero when not armed
    {16'h0020, 16'h1234, 1'b0, 1'b0, 2'd0},  // R8 unknown value
    {16'h0020, 16'h00E0, 1'b0, 1'b0, 2'd0},  // R3 arm
    {16'h0020, 16'h0000, 1'b0, 1'b1, 2'd0}   // R4/R5 confirm, page 4
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample();
    if (resetReq) nRst++;
    if (loadReq) begin nLoad++; gotPage = loadPage; gotBlock = loadBlock; end
    if (idWrEn) begin nId++; gotId[idWrIdx] = idWrData; end
  endtask

  task automatic watch(input int n);
    nRst = 0; nLoad = 0; nId = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      sample();
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    watch(4);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [7:0] expPage;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!resetReq && !loadReq && !idWrEn, "R10 outputs idle in reset",
        {resetReq, loadReq, idWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!resetReq && !loadReq && !idWrEn, "R10 outputs idle after reset",
        {resetReq, loadReq, idWrEn}, 0);

    expPage = 8'h00;
    for (int v = 0; v < NV; v++) begin
      wr(VECS[v][35:20], VECS[v][19:4]);
      chk(nRst == int'(VECS[v][3]), $sformatf("R1/R2 vec%0d reset count", v), nRst, VECS[v][3]);
      chk(nLoad == int'(VECS[v][2]), $sformatf("R3/R4 vec%0d load count", v), nLoad, VECS[v][2]);
      chk(nId == int'(VECS[v][1:0]), $sformatf("R7/R8 vec%0d id writes", v), nId, VECS[v][1:0]);
      if (VECS[v][2]) begin
        chk(gotPage == expPage, $sformatf("R4/R5 vec%0d page", v), gotPage, expPage);
        chk(gotBlock == blockAddr, $sformatf("R4 vec%0d block", v), gotBlock, blockAddr);
        expPage = expPage + 8'd4;
      end
    end
    chk(gotId[0] == 16'h00EC, "R7 entry 0", gotId[0], 16'h00EC);
    chk(gotId[1] == 16'h0025, "R7 entry 1", gotId[1], 16'h0025);
    chk(gotId[2] == 16'h0002, "R7 entry 2", gotId[2], 16'h0002);

    // R9 page write, R5 wrap
    @(negedge clk); pageWrEn = 1'b1; pageWrData = 8'hFC;
    @(negedge clk); pageWrEn = 1'b0;
    blockAddr = 16'h8ABC;
    wr(16'h0005, 16'h00E0); wr(16'h0005, 16'h0000);
    chk(nLoad == 1 && gotPage == 8'hFC, "R9 loaded page used", gotPage, 8'hFC);
    chk(gotBlock == 16'h8ABC, "R4 block follows input", gotBlock, 16'h8ABC);
    wr(16'h8003, 16'h00E0); wr(16'h8003, 16'h0000);
    chk(nLoad == 1 && gotPage == 8'h00, "R5 page wraps to 0", gotPage, 8'h00);

    // R6 busy hold
    @(negedge clk); loadBusy = 1'b1;
    wr(16'h0001, 16'h00E0); wr(16'h0001, 16'h0000);
    chk(nLoad == 0, "R6 no load while busy", nLoad, 0);
    watch(6);
    chk(nLoad == 0, "R6 still waiting", nLoad, 0);
    @(negedge clk); loadBusy = 1'b0;
    @(negedge clk);
    watch(4);
    chk(nLoad == 1, "R6 single pulse after busy", nLoad, 1);
    chk(gotPage == 8'h04, "R6 page of delayed load", gotPage, 8'h04);

    // R2 reset cancels waiting load and clears page
    @(negedge clk); loadBusy = 1'b1;
    wr(16'h0002, 16'h00E0); wr(16'h0002, 16'h0000);
    wr(16'h0002, 16'h00F0);
    chk(nRst == 1, "R2 reset pulse count", nRst, 1);
    @(negedge clk); loadBusy = 1'b0;
    watch(5);
    chk(nLoad == 0, "R2 waiting load cancelled", nLoad, 0);
    wr(16'h0002, 16'h00E0); wr(16'h0002, 16'h0000);
    chk(nLoad == 1 && gotPage == 8'h00, "R2 page cleared by reset", gotPage, 8'h00);

    finish();
  end
endmodule